// File: doc/BRIEF.md
# Bidirectional Port Pin Datapath

This block is the pin-side datapath of a parallel I/O unit with one 8-bit bidirectional port (port C) and one 8-bit output-only port (port B). It holds the port C output register, the port C direction register and the port B output register. For every port C line it produces a drive value and a drive enable, and it returns read-back data for both ports and for the direction register.

Mode information comes from a neighbouring handshake controller: an open-drain (wire-OR) enable, the handshake-enable and output-handshake bits, the acknowledge-polarity select and the already synchronized level of the acknowledge strobe input. In output handshake mode an asserted strobe makes every port C line drive, whatever its direction bit says; this lets the port share a bus with other three-state devices. Register selection arrives as a two-bit code with a single write strobe. Decoding of the full bus address and the flag logic live elsewhere.

Top module: `pinport_unit`

## Requirements
- R1: After reset, `pcOut`, `pbOut`, `dirRead` and `pcOe` are all zero.
- R2: With wire-OR off and no forcing, `pcOe[b]` equals direction bit b (1 = drive, 0 = high-impedance input).
- R3: A write with `regSel` = 0 loads the port C output register even for lines set as inputs; the value appears on `pcOut` without enabling the driver, and drives once the direction bit is set.
- R4: A write with `regSel` = 1 loads the same port C output register as `regSel` = 0.
- R5: Outside output handshake mode, `portCRead[b]` returns `pcPinIn[b]` when direction bit b is 0 and the output register bit when it is 1.
- R6: In output handshake mode (`hndsMode` = 1 and `oinMode` = 1), `portCRead` returns the output register for every bit regardless of direction.
- R7: With `wireOr` = 1, a line that would drive is enabled only when its data bit is 0; a data bit of 1 floats. This also holds for forced lines.
- R8: In output handshake mode with `edgeSel` = 0, `straLevel` = 1 forces all enables on; `straLevel` = 0 returns to direction control.
- R9: In output handshake mode with `edgeSel` = 1, `straLevel` = 0 forces all enables on; `straLevel` = 1 returns to direction control.
- R10: Outside output handshake mode (input handshake or simple strobed), the strobe level never forces the port C enables.
- R11: A write with `regSel` = 3 loads the port B register; `pbOut` and `portBRead` both return it, and port C is untouched.
- R12: `pcOe` is registered: it changes exactly one clock after a change of direction, data, mode or strobe level, never in the same cycle.
- R13: A write with `regSel` = 2 loads the direction register, returned on `dirRead`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Target register: 0 port C, 1 latch alias, 2 direction, 3 port B |
| wrData | input | 8 | Write data |
| wireOr | input | 1 | Open-drain mode for port C |
| hndsMode | input | 1 | Handshake protocol enabled |
| oinMode | input | 1 | Output handshake selected (with hndsMode) |
| edgeSel | input | 1 | Acknowledge polarity select |
| straLevel | input | 1 | Synchronized acknowledge strobe level |
| pcPinIn | input | 8 | Levels sensed at the port C pads |
| pcOut | output | 8 | Port C drive values |
| pcOe | output | 8 | Port C drive enables (registered) |
| pbOut | output | 8 | Port B drive values |
| portCRead | output | 8 | Port C read-back data |
| portBRead | output | 8 | Port B read-back data |
| dirRead | output | 8 | Direction register read-back |

## Verification
The hardest state to reach is a forced drive while the open-drain option is active, since it needs output handshake mode, the right strobe polarity and a data pattern with mixed ones and zeros all at once. The bench first builds a mixed direction pattern, then enters output handshake with the strobe negated, asserts it under each polarity and finally turns on wire-OR, checking that only the zero bits drive. Each enable check samples one cycle after the stimulus and also confirms the old value just before that edge.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

  typedef enum logic [1:0] {
    SEL_PORTC = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_PORTB = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrPortC;
    logic wrDir;
    logic wrPortB;
    logic outHs;
    logic forceAll;
  } ctlStrobe_t;

endpackage

// File: rtl/pinport_ctrl.sv
module pinport_ctrl
  import pinport_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] regSel,
  input  logic       hndsMode,
  input  logic       oinMode,
  input  logic       edgeSel,
  input  logic       straLevel,
  output ctlStrobe_t ctl
);

  regSel_e selCode;
  logic    straAsserted;

  assign selCode      = regSel_e'(regSel);
  // Asserted level is high for edgeSel=0, low for edgeSel=1
  assign straAsserted = edgeSel ? ~straLevel : straLevel;

  always_comb begin
    ctl          = '0;
    ctl.wrPortC  = wrEn && (selCode == SEL_PORTC || selCode == SEL_LATCH);
    ctl.wrDir    = wrEn && (selCode == SEL_DIR);
    ctl.wrPortB  = wrEn && (selCode == SEL_PORTB);
    ctl.outHs    = hndsMode && oinMode;
    ctl.forceAll = ctl.outHs && straAsserted;
  end

  // R10
  no_force_outside_hs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hndsMode || !oinMode) |-> !ctl.forceAll);

  // R4
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrPortC, ctl.wrDir, ctl.wrPortB}));

endmodule

// File: rtl/pinport_dp.sv
module pinport_dp
  import pinport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wireOr,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pcOut,
  output logic [WIDTH-1:0] pcOe,
  output logic [WIDTH-1:0] pbOut,
  output logic [WIDTH-1:0] dirOut,
  output logic [WIDTH-1:0] portCRead,
  output logic [WIDTH-1:0] portBRead
);

  logic [WIDTH-1:0] portCReg;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] portBReg;
  logic [WIDTH-1:0] oeNext;
  logic [WIDTH-1:0] rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portCReg <= '0;
      dirReg   <= '0;
      portBReg <= '0;
    end else begin
      if (ctl.wrPortC) portCReg <= wrData;
      if (ctl.wrDir)   dirReg   <= wrData;
      if (ctl.wrPortB) portBReg <= wrData;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic driveReq;
    assign driveReq  = ctl.forceAll | dirReg[b];
    assign oeNext[b] = driveReq & ~(wireOr & portCReg[b]);
    assign rdMux[b]  = (ctl.outHs | dirReg[b]) ? portCReg[b] : pinIn[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcOe <= '0;
    else       pcOe <= oeNext;
  end

  assign pcOut     = portCReg;
  assign pbOut     = portBReg;
  assign dirOut    = dirReg;
  assign portCRead = rdMux;
  assign portBRead = portBReg;

  // R7
  wireor_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wireOr)) |-> ((pcOe & $past(pcOut)) == '0));

  // R8
  force_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctl.forceAll) && !$past(wireOr)) |-> (pcOe == '1));

  // R2
  dir_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(ctl.forceAll)) |-> ((pcOe & ~$past(dirOut)) == '0));

  // R11
  portb_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctl.wrPortB)) |-> (pbOut == $past(wrData)));

  // R3
  portc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctl.wrPortC)) |-> (pcOut == $past(wrData)));

endmodule

// File: rtl/pinport_unit.sv
module pinport_unit
  import pinport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       regSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wireOr,
  input  logic             hndsMode,
  input  logic             oinMode,
  input  logic             edgeSel,
  input  logic             straLevel,
  input  logic [WIDTH-1:0] pcPinIn,
  output logic [WIDTH-1:0] pcOut,
  output logic [WIDTH-1:0] pcOe,
  output logic [WIDTH-1:0] pbOut,
  output logic [WIDTH-1:0] portCRead,
  output logic [WIDTH-1:0] portBRead,
  output logic [WIDTH-1:0] dirRead
);

  ctlStrobe_t ctl;

  pinport_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .regSel    (regSel),
    .hndsMode  (hndsMode),
    .oinMode   (oinMode),
    .edgeSel   (edgeSel),
    .straLevel (straLevel),
    .ctl       (ctl)
  );

  pinport_dp #(.WIDTH(WIDTH)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrData    (wrData),
    .wireOr    (wireOr),
    .pinIn     (pcPinIn),
    .pcOut     (pcOut),
    .pcOe      (pcOe),
    .pbOut     (pbOut),
    .dirOut    (dirRead),
    .portCRead (portCRead),
    .portBRead (portBRead)
  );

endmodule

// File: tb/test_pinport_unit.sv
`timescale 1ns/1ps
module test_pinport_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic       wireOr = 1'b0;
  logic       hndsMode = 1'b0;
  logic       oinMode = 1'b0;
  logic       edgeSel = 1'b1;
  logic       straLevel = 1'b0;
  logic [7:0] pcPinIn = 8'h00;
  logic [7:0] pcOut, pcOe, pbOut, portCRead, portBRead, dirRead;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pinport_unit i_pinport_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .wireOr(wireOr), .hndsMode(hndsMode), .oinMode(oinMode), .edgeSel(edgeSel),
    .straLevel(straLevel), .pcPinIn(pcPinIn), .pcOut(pcOut), .pcOe(pcOe),
    .pbOut(pbOut), .portCRead(portCRead), .portBRead(portBRead), .dirRead(dirRead)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Write lands at the posedge between the two negedges
  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; regSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check8("R1 pcOut", pcOut, 8'h00);
    check8("R1 pbOut", pbOut, 8'h00);
    check8("R1 dirRead", dirRead, 8'h00);
    check8("R1 pcOe", pcOe, 8'h00);
    pcPinIn = 8'hA5; #1;
    check8("R5 all-input read", portCRead, 8'hA5);
  endtask

  task automatic t_preload();
    writeReg(2'd0, 8'h3C);
    check8("R3 preload value", pcOut, 8'h3C);
    settle();
    check8("R3 no drive while input", pcOe, 8'h00);
    writeReg(2'd2, 8'h0F);
    check8("R13 dir readback", dirRead, 8'h0F);
    check8("R12 oe not yet changed", pcOe, 8'h00);
    settle();
    check8("R2 dir enables", pcOe, 8'h0F);
    check8("R3 preloaded drives", pcOut, 8'h3C);
  endtask

  task automatic t_readMix();
    pcPinIn = 8'hA5; #1;
    check8("R5 mixed read", portCRead, 8'hAC);
    pcPinIn = 8'h00; #1;
    check8("R5 mixed read pins low", portCRead, 8'h0C);
  endtask

  task automatic t_latchAlias();
    writeReg(2'd1, 8'h5A);
    check8("R4 alias write", pcOut, 8'h5A);
    pcPinIn = 8'hA5; #1;
    check8("R4 alias read-back", portCRead, 8'hAA);
  endtask

  task automatic t_dirChange();
    writeReg(2'd2, 8'hF0);
    check8("R12 oe holds old dir", pcOe, 8'h0F);
    settle();
    check8("R2 new dir", pcOe, 8'hF0);
    writeReg(2'd2, 8'h0F);
    settle();
  endtask

  task automatic t_wireOr();
    writeReg(2'd2, 8'hFF);
    settle();
    check8("R2 all out", pcOe, 8'hFF);
    wireOr = 1'b1; #1;
    check8("R12 oe before edge", pcOe, 8'hFF);
    settle();
    check8("R7 open-drain enables", pcOe, 8'hA5);
    wireOr = 1'b0;
    writeReg(2'd2, 8'h0F);
    settle();
    check8("R2 restore", pcOe, 8'h0F);
  endtask

  task automatic t_outHsRead();
    hndsMode = 1'b1; oinMode = 1'b1; edgeSel = 1'b0; straLevel = 1'b0;
    pcPinIn = 8'h00; #1;
    check8("R6 reg read all bits", portCRead, 8'h5A);
    settle();
    check8("R8 negated no force", pcOe, 8'h0F);
  endtask

  task automatic t_forcePol0();
    straLevel = 1'b1; #1;
    check8("R12 force not instant", pcOe, 8'h0F);
    settle();
    check8("R8 high forces", pcOe, 8'hFF);
    straLevel = 1'b0;
    settle();
    check8("R8 low releases", pcOe, 8'h0F);
  endtask

  task automatic t_forcePol1();
    edgeSel = 1'b1; straLevel = 1'b0;
    settle();
    check8("R9 low forces", pcOe, 8'hFF);
    straLevel = 1'b1;
    settle();
    check8("R9 high releases", pcOe, 8'h0F);
  endtask

  task automatic t_forceWireOr();
    edgeSel = 1'b0; straLevel = 1'b1; wireOr = 1'b1;
    settle();
    check8("R7 forced open-drain", pcOe, 8'hA5);
    wireOr = 1'b0; straLevel = 1'b0;
    settle();
  endtask

  task automatic t_noForce();
    oinMode = 1'b0; edgeSel = 1'b0; straLevel = 1'b1;
    pcPinIn = 8'h00;
    settle();
    check8("R10 input hs no force", pcOe, 8'h0F);
    check8("R10 input hs mixed read", portCRead, 8'h0A);
    hndsMode = 1'b0; oinMode = 1'b1;
    settle();
    check8("R10 simple mode no force", pcOe, 8'h0F);
    edgeSel = 1'b1; straLevel = 1'b0;
    settle();
    check8("R10 simple mode pol1 no force", pcOe, 8'h0F);
    oinMode = 1'b0;
  endtask

  task automatic t_portB();
    writeReg(2'd3, 8'hC3);
    check8("R11 pbOut", pbOut, 8'hC3);
    check8("R11 portBRead", portBRead, 8'hC3);
    check8("R11 port C untouched", pcOut, 8'h5A);
    writeReg(2'd3, 8'h3C);
    check8("R11 second write", portBRead, 8'h3C);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    settle();
    check8("R1 after release", pcOe, 8'h00);
    t_preload();
    t_readMix();
    t_latchAlias();
    t_dirChange();
    t_wireOr();
    t_outHsRead();
    t_forcePol0();
    t_forcePol1();
    t_forceWireOr();
    t_noForce();
    t_portB();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule